// File: doc/BRIEF.md
# Hypervisor Interrupt Priority Arbiter

This block decides which pending interrupt a hart that runs a hypervisor should take next. It looks at the machine pending and enable vectors, the two delegation masks, the non-virtual supervisor pending and enable vectors and the identity of an injected virtual interrupt. Each interrupt is assigned to one of three levels: machine, hypervisor-supervisor (HS) or virtual-supervisor (VS). The levels are resolved strictly in that order. Each level is gated by the current privilege, the virtualization flag and the global enable bits. Within the winning level, one interrupt is picked by a fixed default priority.

The decision is registered. A single-cycle take strobe reports it, together with a trap cause word. The strobe fires on the first clock edge at which a winner exists. It then stays quiet until the inputs change again, so the trap logic sees one request for each new interrupt picture. Debug mode, or a resumable-NMI enable that exists and is clear, suppresses every take.

Top module: `hvarb_top`

## Requirements
- R1: Machine candidates are `pend_i & en_i & ~mdeleg_i`. They are eligible when `prv_i` is below machine or when `mie_i` is 1. Privilege encoding: 0 user, 1 supervisor, 3 machine. Whenever eligible machine candidates exist, the winner is one of them, whatever the other levels hold.
- R2: If no machine candidate is eligible, the HS candidates are `(pend_i & mdeleg_i & ~hdeleg_i) | (spend_i & sen_i & ~hdeleg_i)`. They are eligible when `virt_i` is 1, when privilege is user, or when privilege is supervisor with `sie_i` set.
- R3: VS candidates are considered only when `virt_i` is 1 and no HS candidate is eligible. They are `(pend_i & hdeleg_i)` plus the injected bit. They are eligible when privilege is user, or when privilege is supervisor with `sie_i` set.
- R4: The injected bit is bit number `vtop_id_i` when that value is nonzero and below NIRQ, and nothing otherwise. Positions 1, 5 and 9 are then cleared from it.
- R5: When `aia_en_i` is 0, the non-virtual supervisor inputs and the injected bit count as zero.
- R6: No take occurs while `debug_i` is 1, or while `rnmi_present_i` is 1 and `rnmi_en_i` is 0.
- R7: The cause word has bit XLEN-1 set. Its low $clog2(NIRQ) bits hold the index of the winner, and all other bits are 0.
- R8: Within the winning level, the priority order is 11, 3, 7, 9, 1, 5, 12, 10, 2, 6, then every other index from the highest down.
- R9: `take_o` rises for one cycle, on the clock edge after inputs that yield a winner are presented. It fires again only after some input changes. `cause_o` keeps its value between takes.
- R10: During reset, `take_o` is 0 and `cause_o` is 0. The first evaluation after reset counts as a new input picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NIRQ | Machine pending vector |
| en_i | input | NIRQ | Machine enable vector |
| mdeleg_i | input | NIRQ | Machine-to-supervisor delegation mask |
| hdeleg_i | input | NIRQ | Hypervisor-to-virtual delegation mask |
| spend_i | input | NIRQ | Non-virtual supervisor pending vector |
| sen_i | input | NIRQ | Non-virtual supervisor enable vector |
| aia_en_i | input | 1 | Advanced interrupt support enabled |
| vtop_id_i | input | IDW | Identity of the injected virtual interrupt, 0 for none |
| prv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization active |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| rnmi_present_i | input | 1 | Resumable-NMI enable bit is implemented |
| rnmi_en_i | input | 1 | Resumable-NMI enable bit value |
| debug_i | input | 1 | Hart in debug mode |
| take_o | output | 1 | One-cycle take strobe |
| cause_o | output | XLEN | Trap cause word |

## Verification
The bench aims at level ordering where a lower-priority machine bit has to beat a higher-priority HS bit. A design that ranked across levels would pick the HS bit instead. It injects virtual identities at 0, at a supervisor position and beyond NIRQ. A design without the masking or range handling would take a bogus VS interrupt. It holds inputs steady after a take: a design missing the change detector would repeat the strobe every cycle. It toggles the extension enable, the debug flag and the NMI enable, so that leaked supervisor terms and missing blocking both show up as unexpected takes.

// File: rtl/hvarb_pkg.sv
package hvarb_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  typedef enum logic [1:0] {LVL_NONE, LVL_MACH, LVL_HS, LVL_VS} lvl_e;

  // Smaller rank means more urgent.
  function automatic int unsigned prio_rank(input int unsigned idx, input int unsigned nirq);
    case (idx)
      11: return 0;
      3:  return 1;
      7:  return 2;
      9:  return 3;
      1:  return 4;
      5:  return 5;
      12: return 6;
      10: return 7;
      2:  return 8;
      6:  return 9;
      default: return 10 + (nirq - 1 - idx);
    endcase
  endfunction
endpackage

// File: rtl/hvarb_cand.sv
module hvarb_cand
  import hvarb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned IDW  = 6
) (
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] mdeleg_i,
  input  logic [NIRQ-1:0] hdeleg_i,
  input  logic [NIRQ-1:0] spend_i,
  input  logic [NIRQ-1:0] sen_i,
  input  logic            aia_en_i,
  input  logic [IDW-1:0]  vtop_id_i,
  input  logic [1:0]      prv_i,
  input  logic            virt_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic [NIRQ-1:0] m_set_o,
  output logic [NIRQ-1:0] hs_set_o,
  output logic [NIRQ-1:0] vs_set_o
);
  logic [NIRQ-1:0] sup_pos;
  logic [NIRQ-1:0] inj_raw;
  logic [NIRQ-1:0] inj;
  logic [NIRQ-1:0] s_act;
  logic            m_ok, hs_ok, vs_ok;

  // Positions that hold supervisor-level sources; injection never lands there.
  for (genvar g = 0; g < NIRQ; g++) begin : g_sup
    assign sup_pos[g] = (g == 1) || (g == 5) || (g == 9);
  end

  always_comb begin
    inj_raw = NIRQ'(1) << vtop_id_i;
    inj     = inj_raw & ~sup_pos & {NIRQ{aia_en_i && (vtop_id_i != '0)}};
    s_act   = spend_i & sen_i & {NIRQ{aia_en_i}};

    m_ok  = (prv_i != PRV_M) || mie_i;
    vs_ok = (prv_i == PRV_U) || ((prv_i == PRV_S) && sie_i);
    hs_ok = virt_i || vs_ok;

    m_set_o  = pend_i & en_i & ~mdeleg_i & {NIRQ{m_ok}};
    hs_set_o = ((pend_i & mdeleg_i & ~hdeleg_i) | (s_act & ~hdeleg_i)) & {NIRQ{hs_ok}};
    vs_set_o = ((pend_i & hdeleg_i) | inj) & {NIRQ{vs_ok && virt_i}};
  end
endmodule

// File: rtl/hvarb_level.sv
module hvarb_level
  import hvarb_pkg::*;
#(
  parameter int unsigned NIRQ = 16
) (
  input  logic [NIRQ-1:0] m_set_i,
  input  logic [NIRQ-1:0] hs_set_i,
  input  logic [NIRQ-1:0] vs_set_i,
  input  logic            debug_i,
  input  logic            rnmi_present_i,
  input  logic            rnmi_en_i,
  output logic [NIRQ-1:0] win_set_o
);
  lvl_e lvl;
  logic blocked;

  always_comb begin
    blocked = debug_i || (rnmi_present_i && !rnmi_en_i);
    if (blocked)           lvl = LVL_NONE;
    else if (|m_set_i)     lvl = LVL_MACH;
    else if (|hs_set_i)    lvl = LVL_HS;
    else if (|vs_set_i)    lvl = LVL_VS;
    else                   lvl = LVL_NONE;

    unique case (lvl)
      LVL_MACH: win_set_o = m_set_i;
      LVL_HS:   win_set_o = hs_set_i;
      LVL_VS:   win_set_o = vs_set_i;
      default:  win_set_o = '0;
    endcase
  end
endmodule

// File: rtl/hvarb_pick.sv
module hvarb_pick
  import hvarb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  localparam int unsigned IXW = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] set_i,
  output logic            valid_o,
  output logic [IXW-1:0]  idx_o
);
  int unsigned best;

  always_comb begin
    best    = 32'hFFFF_FFFF;
    idx_o   = '0;
    valid_o = |set_i;
    for (int i = 0; i < NIRQ; i++) begin
      if (set_i[i] && (prio_rank(unsigned'(i), NIRQ) < best)) begin
        best  = prio_rank(unsigned'(i), NIRQ);
        idx_o = IXW'(i);
      end
    end
  end
endmodule

// File: rtl/hvarb_pulse.sv
module hvarb_pulse #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IXW  = 4,
  parameter int unsigned INW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [INW-1:0]  snap_i,
  input  logic            valid_i,
  input  logic [IXW-1:0]  idx_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  logic [INW-1:0]  prev_q;
  logic            armed_q, armed_d;
  logic            take_q, take_d;
  logic [XLEN-1:0] cause_q, cause_d;
  logic            eval;

  always_comb begin
    eval    = armed_q || (snap_i != prev_q);
    take_d  = eval && valid_i;
    armed_d = eval && !valid_i;
    cause_d = {1'b1, {(XLEN-1-IXW){1'b0}}, idx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b1;
      take_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      prev_q  <= snap_i;
      armed_q <= armed_d;
      take_q  <= take_d;
      if (take_d) cause_q <= cause_d;
    end
  end

  assign take_o  = take_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/hvarb_top.sv
module hvarb_top
  import hvarb_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned XLEN = 64,
  parameter int unsigned IDW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] mdeleg_i,
  input  logic [NIRQ-1:0] hdeleg_i,
  input  logic [NIRQ-1:0] spend_i,
  input  logic [NIRQ-1:0] sen_i,
  input  logic            aia_en_i,
  input  logic [IDW-1:0]  vtop_id_i,
  input  logic [1:0]      prv_i,
  input  logic            virt_i,
  input  logic            mie_i,
  input  logic            sie_i,
  input  logic            rnmi_present_i,
  input  logic            rnmi_en_i,
  input  logic            debug_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int unsigned IXW = $clog2(NIRQ);
  localparam int unsigned INW = 6*NIRQ + IDW + 9;

  logic [NIRQ-1:0] m_set, hs_set, vs_set, win_set;
  logic            valid;
  logic [IXW-1:0]  idx;
  logic [INW-1:0]  snap;

  assign snap = {pend_i, en_i, mdeleg_i, hdeleg_i, spend_i, sen_i, aia_en_i, vtop_id_i,
                 prv_i, virt_i, mie_i, sie_i, rnmi_present_i, rnmi_en_i, debug_i};

  hvarb_cand #(.NIRQ(NIRQ), .IDW(IDW)) u_cand (
    .pend_i(pend_i), .en_i(en_i), .mdeleg_i(mdeleg_i), .hdeleg_i(hdeleg_i),
    .spend_i(spend_i), .sen_i(sen_i), .aia_en_i(aia_en_i), .vtop_id_i(vtop_id_i),
    .prv_i(prv_i), .virt_i(virt_i), .mie_i(mie_i), .sie_i(sie_i),
    .m_set_o(m_set), .hs_set_o(hs_set), .vs_set_o(vs_set)
  );

  hvarb_level #(.NIRQ(NIRQ)) u_level (
    .m_set_i(m_set), .hs_set_i(hs_set), .vs_set_i(vs_set),
    .debug_i(debug_i), .rnmi_present_i(rnmi_present_i), .rnmi_en_i(rnmi_en_i),
    .win_set_o(win_set)
  );

  hvarb_pick #(.NIRQ(NIRQ)) u_pick (
    .set_i(win_set), .valid_o(valid), .idx_o(idx)
  );

  hvarb_pulse #(.XLEN(XLEN), .IXW(IXW), .INW(INW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .snap_i(snap), .valid_i(valid), .idx_i(idx),
    .take_o(take_o), .cause_o(cause_o)
  );
endmodule

// File: rtl/hvarb_chk.sv
module hvarb_chk #(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned XLEN = 64,
  parameter int unsigned IDW  = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] pend_i,
  input logic [NIRQ-1:0] en_i,
  input logic [NIRQ-1:0] mdeleg_i,
  input logic [NIRQ-1:0] hdeleg_i,
  input logic [NIRQ-1:0] spend_i,
  input logic [NIRQ-1:0] sen_i,
  input logic            aia_en_i,
  input logic [IDW-1:0]  vtop_id_i,
  input logic [1:0]      prv_i,
  input logic            virt_i,
  input logic            mie_i,
  input logic            sie_i,
  input logic            rnmi_present_i,
  input logic            rnmi_en_i,
  input logic            debug_i,
  input logic            take_o,
  input logic [XLEN-1:0] cause_o
);
  localparam int unsigned IXW = $clog2(NIRQ);

  logic [6*NIRQ+IDW+8:0] ins;
  logic [NIRQ-1:0]       mc;
  logic                  m_live;

  assign ins = {debug_i, rnmi_en_i, rnmi_present_i, sie_i, mie_i, virt_i, prv_i,
                vtop_id_i, aia_en_i, sen_i, spend_i, hdeleg_i, mdeleg_i, en_i, pend_i};
  assign mc     = pend_i & en_i & ~mdeleg_i;
  assign m_live = ((prv_i != 2'd3) || mie_i) && (|mc);

  // R1: an eligible machine candidate always wins over the other levels
  assert_mach_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && $past(m_live) |-> |(($past(mc) >> cause_o[IXW-1:0]) & NIRQ'(1)));

  // R6: blocking conditions suppress the next strobe
  assert_debug_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    debug_i |=> !take_o);
  assert_rnmi_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rnmi_present_i && !rnmi_en_i) |=> !take_o);

  // R7: cause word format
  assert_cause_fmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cause_o[XLEN-1] && (cause_o[XLEN-2:0] < (XLEN-1)'(NIRQ)));

  // R9: single pulse while inputs hold, cause held between takes
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && $stable(ins) |=> !take_o);
  assert_cause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(cause_o));
endmodule

bind hvarb_top hvarb_chk #(.NIRQ(NIRQ), .XLEN(XLEN), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .mdeleg_i(mdeleg_i),
  .hdeleg_i(hdeleg_i), .spend_i(spend_i), .sen_i(sen_i), .aia_en_i(aia_en_i),
  .vtop_id_i(vtop_id_i), .prv_i(prv_i), .virt_i(virt_i), .mie_i(mie_i), .sie_i(sie_i),
  .rnmi_present_i(rnmi_present_i), .rnmi_en_i(rnmi_en_i), .debug_i(debug_i),
  .take_o(take_o), .cause_o(cause_o)
);

// File: tb/hvarb_top_tb.sv
`timescale 1ns/1ps
module hvarb_top_tb;
  localparam int NIRQ = 16;
  localparam int XLEN = 64;
  localparam int IDW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIRQ-1:0] pend, en, mdeleg, hdeleg, spend, sen;
  logic aia, virt, mie, sie, rp, re, dbg;
  logic [IDW-1:0] vid;
  logic [1:0] prv;
  logic take;
  logic [XLEN-1:0] cause;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R10";
  bit finished = 0;

  always #4 clk = ~clk;

  hvarb_top #(.NIRQ(NIRQ), .XLEN(XLEN), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .mdeleg_i(mdeleg), .hdeleg_i(hdeleg),
    .spend_i(spend), .sen_i(sen), .aia_en_i(aia), .vtop_id_i(vid), .prv_i(prv),
    .virt_i(virt), .mie_i(mie), .sie_i(sie), .rnmi_present_i(rp), .rnmi_en_i(re),
    .debug_i(dbg), .take_o(take), .cause_o(cause)
  );

  // ---------------- behavioural reference ----------------
  int order[10] = '{11, 3, 7, 9, 1, 5, 12, 10, 2, 6};

  function automatic int best_of(input logic [NIRQ-1:0] s);
    for (int k = 0; k < 10; k++) if (s[order[k]]) return order[k];
    for (int i = NIRQ-1; i >= 0; i--) begin
      bit listed = 0;
      for (int k = 0; k < 10; k++) if (order[k] == i) listed = 1;
      if (!listed && s[i]) return i;
    end
    return -1;
  endfunction

  function automatic int ref_pick();
    logic [NIRQ-1:0] sact, inj, mset, hset, vset;
    bit low_ok;
    if (dbg || (rp && !re)) return -1;
    sact = aia ? (spend & sen) : '0;
    inj = '0;
    if (aia && vid != 0 && int'(vid) < NIRQ && vid != 1 && vid != 5 && vid != 9) inj[vid] = 1'b1;
    low_ok = (prv == 2'd0) || (prv == 2'd1 && sie);
    mset = pend & en & ~mdeleg;
    if ((prv != 2'd3 || mie) && mset != 0) return best_of(mset);
    hset = (pend & mdeleg & ~hdeleg) | (sact & ~hdeleg);
    if ((virt || low_ok) && hset != 0) return best_of(hset);
    vset = (pend & hdeleg) | inj;
    if (virt && low_ok && vset != 0) return best_of(vset);
    return -1;
  endfunction

  logic [6*NIRQ+IDW+8:0] m_prev;
  bit m_armed, m_take;
  logic [XLEN-1:0] m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_armed = 1; m_take = 0; m_cause = '0;
    end else begin
      logic [6*NIRQ+IDW+8:0] cur;
      bit ev;
      int p;
      cur = {pend, en, mdeleg, hdeleg, spend, sen, aia, vid, prv, virt, mie, sie, rp, re, dbg};
      ev = m_armed || (cur != m_prev);
      p = ref_pick();
      m_take = ev && (p >= 0);
      if (m_take) begin
        m_cause = '0;
        m_cause[XLEN-1] = 1'b1;
        m_cause[3:0] = 4'(p);
      end
      m_armed = ev && (p < 0);
      m_prev = cur;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (take !== m_take || cause !== m_cause) begin
        fails++;
        $display("FAIL %s model compare: take=%0b cause=%h expected take=%0b cause=%h",
                 cur_tag, take, cause, m_take, m_cause);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic defaults();
    pend = '0; en = '0; mdeleg = '0; hdeleg = '0; spend = '0; sen = '0;
    aia = 1; vid = '0; prv = 2'd3; virt = 0; mie = 1; sie = 0; rp = 0; re = 0; dbg = 0;
  endtask

  task automatic step(input string tag, input bit et, input int eidx);
    logic [XLEN-1:0] ec;
    cur_tag = tag;
    @(posedge clk);
    @(negedge clk);
    checks++;
    ec = '0;
    if (et) begin ec[XLEN-1] = 1'b1; ec[3:0] = 4'(eidx); end
    if (take !== et || (et && cause !== ec)) begin
      fails++;
      $display("FAIL %s directed: take=%0b cause=%h expected take=%0b cause=%h",
               tag, take, cause, et, ec);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    finish_run();
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    checks++;
    if (take !== 1'b0 || cause !== '0) begin
      fails++;
      $display("FAIL R10 reset: take=%0b cause=%h expected 0/0", take, cause);
    end
    rst_n = 1'b1;
    step("R10", 0, 0);

    // R1 machine level
    pend = 16'h0080; en = 16'h0080; step("R1", 1, 7);
    mie = 0; step("R1", 0, 0);
    prv = 2'd0; pend = 16'h0888; en = 16'h0888; step("R8", 1, 11);
    pend = 16'h0088; step("R8", 1, 3);
    pend = 16'h3004; en = 16'h3004; step("R8", 1, 12);
    pend = 16'h2001; en = 16'h2001; step("R8", 1, 13);
    pend = 16'h0222; en = 16'h0222; step("R8", 1, 9);

    // R2 HS level
    prv = 2'd1; sie = 1; mdeleg = 16'h0220; pend = 16'h0220; en = 16'h0220;
    step("R2", 1, 9);
    sie = 0; step("R2", 0, 0);
    sie = 1; mdeleg = 16'h0800; pend = 16'h0804; en = 16'h0804;
    step("R1", 1, 2);
    defaults(); prv = 2'd1; sie = 1; spend = 16'h2000; sen = 16'h2000;
    step("R2", 1, 13);
    aia = 0; step("R5", 0, 0);

    // R3 VS level
    defaults(); virt = 1; prv = 2'd1; sie = 1; mdeleg = 16'h0400; hdeleg = 16'h0400;
    pend = 16'h0400; en = 16'h0400; step("R3", 1, 10);
    sie = 0; step("R3", 0, 0);
    prv = 2'd0; step("R3", 1, 10);
    defaults(); virt = 1; prv = 2'd1; mdeleg = 16'h0200; pend = 16'h0200; en = 16'h0200;
    step("R2", 1, 9);

    // R4 / R5 injection
    defaults(); virt = 1; prv = 2'd0; vid = 6'd13; step("R4", 1, 13);
    vid = 6'd5; step("R4", 0, 0);
    vid = 6'd0; step("R4", 0, 0);
    vid = 6'd20; step("R4", 0, 0);
    vid = 6'd14; step("R4", 1, 14);
    aia = 0; step("R5", 0, 0);
    aia = 1; virt = 0; vid = 6'd13; step("R3", 0, 0);

    // R6 blocking
    defaults(); pend = 16'h0008; en = 16'h0008; dbg = 1; step("R6", 0, 0);
    dbg = 0; rp = 1; re = 0; step("R6", 0, 0);
    re = 1; step("R6", 1, 3);

    // R9 pulse behaviour
    defaults(); prv = 2'd0; pend = 16'h0040; en = 16'h0040; step("R9", 1, 6);
    step("R9", 0, 6);
    step("R9", 0, 6);
    checks++;
    if (cause !== {1'b1, 59'd0, 4'd6}) begin
      fails++;
      $display("FAIL R9 cause hold: cause=%h expected %h", cause, {1'b1, 59'd0, 4'd6});
    end
    en = 16'h4040; step("R9", 1, 6);
    step("R7", 0, 6);

    // broad pseudo-random phase, compared against the model each clock
    cur_tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pend = 16'($urandom); en = 16'($urandom); mdeleg = 16'($urandom);
      hdeleg = 16'($urandom); spend = 16'($urandom); sen = 16'($urandom);
      aia = 1'($urandom); vid = 6'($urandom % 24); prv = 2'($urandom);
      virt = 1'($urandom); mie = 1'($urandom); sie = 1'($urandom);
      rp = 1'($urandom); re = 1'($urandom); dbg = (($urandom % 8) == 0);
      if (($urandom % 4) == 0) begin pend = pend & 16'h0F0F; en = 16'h0000; end
      if (($urandom % 3) == 0) begin @(negedge clk); @(negedge clk); end
    end
    @(negedge clk);
    finish_run();
  end
endmodule